// File: doc/BRIEF.md
# CAN Receive Message Buffer Allocator

This block decides which of sixteen message buffers receives a CAN frame that the protocol engine has finished and the acceptance comparators have matched. The comparators give one hit bit per buffer, and the host keeps one enable bit per buffer. When the engine pulses the frame-complete strobe, the block registers the eligible set (hit and enabled) together with the frame contents. In the next cycle it writes the frame into the lowest-numbered eligible buffer. It also updates that buffer's status flags and the pointer to the last buffer written.

The eligibility snapshot is taken in a single register stage. A host write to the enable mask in the same cycle as the strobe therefore applies only to the following frame. The frame is never redirected to another buffer, such as buffer 0. The host reads any stored frame through a combinational read port. It clears the per-buffer received, overrun and remote flags by writing ones.

Top module: `can_rx_buf_alloc`

## Requirements
- R1: After reset, buf_en, done_flags, ovr_flags and rmt_flags are all zero and last_idx is 0.
- R2: A frame is stored only on a cycle with frame_done high. Two rising edges after that strobe cycle, the stored identifier, extended bit, remote bit, length and payload can be read on the rd_* outputs when rd_sel selects the buffer. acc_hit without frame_done stores nothing.
- R3: Among the buffers that are both hit and enabled, the one with the lowest index receives the frame. Buffer 0 has the highest priority.
- R4: A buffer whose buf_en bit is 0 never receives a frame. The next hit buffer that is enabled is chosen instead.
- R5: On a store, last_idx becomes the index of the written buffer and that buffer's done_flags bit is set.
- R6: If a buffer is written while its done_flags bit is already 1, its ovr_flags bit is set.
- R7: If the stored frame has rx_rmt = 1, the written buffer's rmt_flags bit is set.
- R8: If no buffer is both hit and enabled, nothing is stored, no flag changes and last_idx keeps its value.
- R9: The enable mask used for a frame is the buf_en value in the strobe cycle. A bufen_wr in that same cycle affects only later frames.
- R10: Writing 1 to a bit of clr_done, clr_ovr or clr_rmt clears that flag on the next edge. A set of the same flag in the same cycle wins over the clear.
- R11: When bufen_wr is high, buf_en takes bufen_wdata on the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bufen_wr | input | 1 | Host write strobe for the enable mask |
| bufen_wdata | input | 16 | New enable mask |
| buf_en | output | 16 | Current per-buffer enable mask |
| frame_done | input | 1 | Frame complete and error-free strobe |
| acc_hit | input | 16 | Per-buffer acceptance match |
| rx_ident | input | 29 | Received identifier |
| rx_ext | input | 1 | Received extended-format bit |
| rx_rmt | input | 1 | Received remote-request bit |
| rx_len | input | 4 | Received length code |
| rx_payload | input | 64 | Received data bytes |
| clr_done | input | 16 | Write-1-to-clear for the received flags |
| clr_ovr | input | 16 | Write-1-to-clear for the overrun flags |
| clr_rmt | input | 16 | Write-1-to-clear for the remote flags |
| done_flags | output | 16 | Per-buffer received flags |
| ovr_flags | output | 16 | Per-buffer overrun flags |
| rmt_flags | output | 16 | Per-buffer remote-frame flags |
| last_idx | output | 4 | Index of the last buffer written |
| rd_sel | input | 4 | Buffer selected for reading |
| rd_ident | output | 29 | Identifier of the selected buffer |
| rd_ext | output | 1 | Extended bit of the selected buffer |
| rd_rmt | output | 1 | Remote bit of the selected buffer |
| rd_len | output | 4 | Length code of the selected buffer |
| rd_payload | output | 64 | Data of the selected buffer |

## Verification
The two functions that can fall in the same cycle are a host write that disables a buffer and the frame-complete strobe that chooses a buffer. The bench raises bufen_wr, clearing the enable of the buffer that would win, in the very cycle of frame_done. It judges the result by the buffer that was written (last_idx and done_flags), by the new mask read back on buf_en, and by a second frame that must then skip the disabled buffer. A flag clear landing in the same cycle as a store into that buffer is provoked in the same way; the bench expects the set to win.

// File: rtl/can_rxalloc_pkg.sv
package can_rxalloc_pkg;
  localparam int unsigned CAN_ID_W   = 29;
  localparam int unsigned CAN_LEN_W  = 4;
  localparam int unsigned CAN_DATA_W = 64;

  typedef struct packed {
    logic [CAN_ID_W-1:0]   ident;
    logic                  ext;
    logic                  rmt;
    logic [CAN_LEN_W-1:0]  len;
    logic [CAN_DATA_W-1:0] payload;
  } can_frame_t;
endpackage

// File: rtl/rxa_capture.sv
module rxa_capture
  import can_rxalloc_pkg::*;
#(
  parameter int unsigned NUM_BUF = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frame_done,
  input  logic [NUM_BUF-1:0] acc_hit,
  input  logic [NUM_BUF-1:0] buf_en,
  input  can_frame_t         frame_in,
  output logic               snap_vld,
  output logic [NUM_BUF-1:0] snap_elig,
  output can_frame_t         snap_frame
);
  logic               vld_d;
  logic [NUM_BUF-1:0] elig_d;
  can_frame_t         frame_d;

  // hit and enable are sampled in one edge, so they form a single coherent view
  always_comb begin
    vld_d   = frame_done;
    elig_d  = frame_done ? (acc_hit & buf_en) : '0;
    frame_d = frame_done ? frame_in : snap_frame;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap_vld   <= 1'b0;
      snap_elig  <= '0;
      snap_frame <= '0;
    end else begin
      snap_vld   <= vld_d;
      snap_elig  <= elig_d;
      snap_frame <= frame_d;
    end
  end
endmodule

// File: rtl/rxa_pick.sv
module rxa_pick #(
  parameter int unsigned NUM_BUF = 16,
  parameter int unsigned IDX_W   = $clog2(NUM_BUF)
) (
  input  logic [NUM_BUF-1:0] elig,
  output logic               any,
  output logic [IDX_W-1:0]   win_idx,
  output logic [NUM_BUF-1:0] win_vec
);
  always_comb begin
    any     = |elig;
    win_idx = '0;
    for (int i = NUM_BUF - 1; i >= 0; i--) begin
      if (elig[i]) win_idx = IDX_W'(i);
    end
  end

  for (genvar g = 0; g < NUM_BUF; g++) begin : g_vec
    if (g == 0) begin : g_first
      assign win_vec[g] = elig[g];
    end else begin : g_rest
      assign win_vec[g] = elig[g] & ~(|elig[g-1:0]);
    end
  end
endmodule

// File: rtl/rxa_store.sv
module rxa_store
  import can_rxalloc_pkg::*;
#(
  parameter int unsigned NUM_BUF = 16,
  parameter int unsigned IDX_W   = $clog2(NUM_BUF)
) (
  input  logic               clk,
  input  logic [NUM_BUF-1:0] wr_vec,
  input  can_frame_t         wr_frame,
  input  logic [IDX_W-1:0]   rd_sel,
  output can_frame_t         rd_frame
);
  can_frame_t mem [NUM_BUF];

  // storage carries no reset: contents are valid only behind a done flag
  always_ff @(posedge clk) begin
    for (int i = 0; i < NUM_BUF; i++) begin
      if (wr_vec[i]) mem[i] <= wr_frame;
    end
  end

  assign rd_frame = mem[rd_sel];
endmodule

// File: rtl/rxa_flag_bank.sv
module rxa_flag_bank #(
  parameter int unsigned NUM_BUF = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_BUF-1:0] wr_vec,
  input  logic               wr_rmt,
  input  logic [NUM_BUF-1:0] clr_done,
  input  logic [NUM_BUF-1:0] clr_ovr,
  input  logic [NUM_BUF-1:0] clr_rmt,
  output logic [NUM_BUF-1:0] done_q,
  output logic [NUM_BUF-1:0] ovr_q,
  output logic [NUM_BUF-1:0] rmt_q
);
  logic [NUM_BUF-1:0] done_d;
  logic [NUM_BUF-1:0] ovr_d;
  logic [NUM_BUF-1:0] rmt_d;

  // set terms are OR-ed after the clear, so a set wins
  always_comb begin
    done_d = (done_q & ~clr_done) | wr_vec;
    ovr_d  = (ovr_q  & ~clr_ovr)  | (wr_vec & done_q);
    rmt_d  = (rmt_q  & ~clr_rmt)  | (wr_vec & {NUM_BUF{wr_rmt}});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= '0;
      ovr_q  <= '0;
      rmt_q  <= '0;
    end else begin
      done_q <= done_d;
      ovr_q  <= ovr_d;
      rmt_q  <= rmt_d;
    end
  end

  for (genvar g = 0; g < NUM_BUF; g++) begin : g_chk
    assert_done_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done_q[g]) |-> $past(wr_vec[g]));
    assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
      wr_vec[g] |=> done_q[g]);
    assert_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_done[g] && !wr_vec[g]) |=> !done_q[g]);
    assert_ovr_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovr_q[g]) |-> $past(wr_vec[g] && done_q[g]));
    assert_rmt_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rmt_q[g]) |-> $past(wr_vec[g] && wr_rmt));
  end
endmodule

// File: rtl/can_rx_buf_alloc.sv
module can_rx_buf_alloc
  import can_rxalloc_pkg::*;
#(
  parameter int unsigned NUM_BUF = 16,
  parameter int unsigned IDX_W   = $clog2(NUM_BUF)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bufen_wr,
  input  logic [NUM_BUF-1:0]    bufen_wdata,
  output logic [NUM_BUF-1:0]    buf_en,
  input  logic                  frame_done,
  input  logic [NUM_BUF-1:0]    acc_hit,
  input  logic [CAN_ID_W-1:0]   rx_ident,
  input  logic                  rx_ext,
  input  logic                  rx_rmt,
  input  logic [CAN_LEN_W-1:0]  rx_len,
  input  logic [CAN_DATA_W-1:0] rx_payload,
  input  logic [NUM_BUF-1:0]    clr_done,
  input  logic [NUM_BUF-1:0]    clr_ovr,
  input  logic [NUM_BUF-1:0]    clr_rmt,
  output logic [NUM_BUF-1:0]    done_flags,
  output logic [NUM_BUF-1:0]    ovr_flags,
  output logic [NUM_BUF-1:0]    rmt_flags,
  output logic [IDX_W-1:0]      last_idx,
  input  logic [IDX_W-1:0]      rd_sel,
  output logic [CAN_ID_W-1:0]   rd_ident,
  output logic                  rd_ext,
  output logic                  rd_rmt,
  output logic [CAN_LEN_W-1:0]  rd_len,
  output logic [CAN_DATA_W-1:0] rd_payload
);
  can_frame_t         frame_in;
  can_frame_t         snap_frame;
  can_frame_t         rd_frame;
  logic               snap_vld;
  logic [NUM_BUF-1:0] snap_elig;
  logic               any_elig;
  logic [IDX_W-1:0]   win_idx;
  logic [NUM_BUF-1:0] win_vec;
  logic               commit;
  logic [NUM_BUF-1:0] wr_vec;
  logic [NUM_BUF-1:0] buf_en_d;
  logic [IDX_W-1:0]   last_idx_d;

  assign frame_in = '{ident: rx_ident, ext: rx_ext, rmt: rx_rmt,
                      len: rx_len, payload: rx_payload};

  rxa_capture #(.NUM_BUF(NUM_BUF)) u_capture (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_done (frame_done),
    .acc_hit    (acc_hit),
    .buf_en     (buf_en),
    .frame_in   (frame_in),
    .snap_vld   (snap_vld),
    .snap_elig  (snap_elig),
    .snap_frame (snap_frame)
  );

  rxa_pick #(.NUM_BUF(NUM_BUF), .IDX_W(IDX_W)) u_pick (
    .elig    (snap_elig),
    .any     (any_elig),
    .win_idx (win_idx),
    .win_vec (win_vec)
  );

  assign commit = snap_vld & any_elig;
  assign wr_vec = commit ? win_vec : '0;

  rxa_store #(.NUM_BUF(NUM_BUF), .IDX_W(IDX_W)) u_store (
    .clk      (clk),
    .wr_vec   (wr_vec),
    .wr_frame (snap_frame),
    .rd_sel   (rd_sel),
    .rd_frame (rd_frame)
  );

  rxa_flag_bank #(.NUM_BUF(NUM_BUF)) u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_vec   (wr_vec),
    .wr_rmt   (snap_frame.rmt),
    .clr_done (clr_done),
    .clr_ovr  (clr_ovr),
    .clr_rmt  (clr_rmt),
    .done_q   (done_flags),
    .ovr_q    (ovr_flags),
    .rmt_q    (rmt_flags)
  );

  always_comb begin
    buf_en_d   = bufen_wr ? bufen_wdata : buf_en;
    last_idx_d = commit ? win_idx : last_idx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_en   <= '0;
      last_idx <= '0;
    end else begin
      buf_en   <= buf_en_d;
      last_idx <= last_idx_d;
    end
  end

  assign rd_ident   = rd_frame.ident;
  assign rd_ext     = rd_frame.ext;
  assign rd_rmt     = rd_frame.rmt;
  assign rd_len     = rd_frame.len;
  assign rd_payload = rd_frame.payload;

  logic [NUM_BUF-1:0] below_win;
  assign below_win = (NUM_BUF'(1) << win_idx) - NUM_BUF'(1);

  assert_enabled_hit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> |($past(buf_en & acc_hit) & win_vec));
  assert_lowest_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> (($past(buf_en & acc_hit) & below_win) == '0));
  assert_pick_agree_R3: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> (win_vec == (NUM_BUF'(1) << win_idx)));
  assert_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(last_idx));
  assert_one_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_vec));
  assert_mask_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
    bufen_wr |=> (buf_en == $past(bufen_wdata)));
endmodule

// File: tb/can_rx_buf_alloc_tb.sv
`timescale 1ns/1ps
module can_rx_buf_alloc_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bufen_wr;
  logic [15:0] bufen_wdata;
  logic [15:0] buf_en;
  logic        frame_done;
  logic [15:0] acc_hit;
  logic [28:0] rx_ident;
  logic        rx_ext;
  logic        rx_rmt;
  logic [3:0]  rx_len;
  logic [63:0] rx_payload;
  logic [15:0] clr_done;
  logic [15:0] clr_ovr;
  logic [15:0] clr_rmt;
  logic [15:0] done_flags;
  logic [15:0] ovr_flags;
  logic [15:0] rmt_flags;
  logic [3:0]  last_idx;
  logic [3:0]  rd_sel;
  logic [28:0] rd_ident;
  logic        rd_ext;
  logic        rd_rmt;
  logic [3:0]  rd_len;
  logic [63:0] rd_payload;

  int checks = 0;
  int errors = 0;
  logic [3:0] exp_last;

  always #2.5 clk = ~clk;

  can_rx_buf_alloc u_dut (
    .clk(clk), .rst_n(rst_n), .bufen_wr(bufen_wr), .bufen_wdata(bufen_wdata),
    .buf_en(buf_en), .frame_done(frame_done), .acc_hit(acc_hit),
    .rx_ident(rx_ident), .rx_ext(rx_ext), .rx_rmt(rx_rmt), .rx_len(rx_len),
    .rx_payload(rx_payload), .clr_done(clr_done), .clr_ovr(clr_ovr),
    .clr_rmt(clr_rmt), .done_flags(done_flags), .ovr_flags(ovr_flags),
    .rmt_flags(rmt_flags), .last_idx(last_idx), .rd_sel(rd_sel),
    .rd_ident(rd_ident), .rd_ext(rd_ext), .rd_rmt(rd_rmt), .rd_len(rd_len),
    .rd_payload(rd_payload)
  );

  typedef struct packed {
    logic [15:0] mask;
    logic [15:0] hit;
    logic [28:0] id;
    logic        rtr;
    logic        stored;
    logic [3:0]  idx;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VEC [NV] = '{
    '{16'hFFFF, 16'h0001, 29'h0000123, 1'b0, 1'b1, 4'd0},
    '{16'hFFFF, 16'h8000, 29'h1F00ABC, 1'b0, 1'b1, 4'd15},
    '{16'hFFFF, 16'h0C30, 29'h0345678, 1'b1, 1'b1, 4'd4},
    '{16'hFFEF, 16'h0C30, 29'h0000777, 1'b0, 1'b1, 4'd5},
    '{16'h0000, 16'hFFFF, 29'h0000555, 1'b0, 1'b0, 4'd0},
    '{16'hF0F0, 16'h0F0F, 29'h0000666, 1'b0, 1'b0, 4'd0},
    '{16'h8001, 16'hFFFE, 29'h1234567, 1'b1, 1'b1, 4'd15},
    '{16'hFFFE, 16'h0003, 29'h0ABCDEF, 1'b0, 1'b1, 4'd1},
    '{16'h00FF, 16'h0000, 29'h0000042, 1'b0, 1'b0, 4'd0}
  };

  function automatic logic [63:0] pay_of(input logic [28:0] id);
    return {id[15:0], ~id[15:0], id[28:0], 3'b101} ^ 64'hA5A5_0000_0000_5A5A;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clear_all();
    @(negedge clk);
    clr_done = '1; clr_ovr = '1; clr_rmt = '1;
    @(negedge clk);
    clr_done = '0; clr_ovr = '0; clr_rmt = '0;
  endtask

  task automatic write_mask(input logic [15:0] m);
    @(negedge clk);
    bufen_wr = 1'b1; bufen_wdata = m;
    @(negedge clk);
    bufen_wr = 1'b0;
  endtask

  task automatic drive_frame(input logic [15:0] hit, input logic [28:0] id,
                             input logic ext, input logic rtr, input logic [3:0] len);
    frame_done = 1'b1; acc_hit = hit; rx_ident = id; rx_ext = ext;
    rx_rmt = rtr; rx_len = len; rx_payload = pay_of(id);
  endtask

  task automatic idle_frame();
    frame_done = 1'b0; acc_hit = '0;
  endtask

  // strobe, capture edge, commit edge, then sample
  task automatic send_frame(input logic [15:0] hit, input logic [28:0] id,
                            input logic ext, input logic rtr, input logic [3:0] len);
    @(negedge clk);
    drive_frame(hit, id, ext, rtr, len);
    @(negedge clk);
    idle_frame();
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bufen_wr = 1'b0; bufen_wdata = '0; frame_done = 1'b0;
    acc_hit = '0; rx_ident = '0; rx_ext = 1'b0; rx_rmt = 1'b0; rx_len = '0;
    rx_payload = '0; clr_done = '0; clr_ovr = '0; clr_rmt = '0; rd_sel = '0;
    exp_last = 4'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 buf_en", 64'(buf_en), 64'h0);
    chk("R1 done_flags", 64'(done_flags), 64'h0);
    chk("R1 ovr_flags", 64'(ovr_flags), 64'h0);
    chk("R1 rmt_flags", 64'(rmt_flags), 64'h0);
    chk("R1 last_idx", 64'(last_idx), 64'h0);

    // table walk: R3 R4 R5 R7 R8 R11
    for (int k = 0; k < NV; k++) begin
      clear_all();
      write_mask(VEC[k].mask);
      chk("R11 mask write", 64'(buf_en), 64'(VEC[k].mask));
      send_frame(VEC[k].hit, VEC[k].id, 1'b0, VEC[k].rtr, 4'd8);
      if (VEC[k].stored) exp_last = VEC[k].idx;
      chk("R3/R4 last_idx", 64'(last_idx), 64'(exp_last));
      chk("R5/R8 done_flags", 64'(done_flags),
          VEC[k].stored ? (64'h1 << VEC[k].idx) : 64'h0);
      chk("R7 rmt_flags", 64'(rmt_flags),
          (VEC[k].stored && VEC[k].rtr) ? (64'h1 << VEC[k].idx) : 64'h0);
      if (VEC[k].stored) begin
        rd_sel = VEC[k].idx;
        #1;
        chk("R2 rd_ident", 64'(rd_ident), 64'(VEC[k].id));
      end
    end

    // R9 disable in the same cycle as the strobe
    clear_all();
    write_mask(16'hFFFF);
    @(negedge clk);
    drive_frame(16'h0006, 29'h1ABCDEF, 1'b0, 1'b0, 4'd2);
    bufen_wr = 1'b1; bufen_wdata = 16'hFFFD;
    @(negedge clk);
    idle_frame();
    bufen_wr = 1'b0;
    @(negedge clk);
    chk("R9 old mask used", 64'(last_idx), 64'd1);
    chk("R9 done", 64'(done_flags), 64'h0002);
    chk("R9/R11 new mask", 64'(buf_en), 64'hFFFD);
    send_frame(16'h0006, 29'h0000999, 1'b0, 1'b0, 4'd2);
    chk("R9 next frame skips", 64'(last_idx), 64'd2);
    chk("R9 done next", 64'(done_flags), 64'h0006);

    // R6 overrun
    clear_all();
    send_frame(16'h0008, 29'h0000301, 1'b0, 1'b0, 4'd1);
    chk("R6 first store no ovr", 64'(ovr_flags), 64'h0);
    send_frame(16'h0008, 29'h0000302, 1'b0, 1'b0, 4'd1);
    chk("R6 second store ovr", 64'(ovr_flags), 64'h0008);
    rd_sel = 4'd3;
    #1;
    chk("R2 newest frame kept", 64'(rd_ident), 64'h302);

    // R7 and R2 full readback
    clear_all();
    send_frame(16'h0020, 29'h15555555, 1'b1, 1'b1, 4'd3);
    chk("R7 rmt set", 64'(rmt_flags), 64'h0020);
    rd_sel = 4'd5;
    #1;
    chk("R2 rd_ident", 64'(rd_ident), 64'h15555555);
    chk("R2 rd_ext", 64'(rd_ext), 64'h1);
    chk("R2 rd_rmt", 64'(rd_rmt), 64'h1);
    chk("R2 rd_len", 64'(rd_len), 64'h3);
    chk("R2 rd_payload", rd_payload, pay_of(29'h15555555));
    send_frame(16'h0040, 29'h0000400, 1'b0, 1'b0, 4'd4);
    chk("R7 data frame no rmt", 64'(rmt_flags), 64'h0020);

    // R10 clear coinciding with a store
    @(negedge clk);
    drive_frame(16'h0040, 29'h0000401, 1'b0, 1'b0, 4'd4);
    @(negedge clk);
    idle_frame();
    clr_done = 16'h0060;
    @(negedge clk);
    clr_done = '0;
    chk("R10 set wins, other clears", 64'(done_flags), 64'h0040);
    chk("R6 ovr on coincident store", 64'(ovr_flags), 64'h0040);
    @(negedge clk);
    clr_rmt = 16'h0020;
    @(negedge clk);
    clr_rmt = '0;
    chk("R10 rmt clear", 64'(rmt_flags), 64'h0);

    // R2 hit without strobe stores nothing
    clear_all();
    @(negedge clk);
    acc_hit = 16'hFFFF;
    repeat (3) @(negedge clk);
    acc_hit = '0;
    @(negedge clk);
    chk("R2 no strobe done", 64'(done_flags), 64'h0);
    chk("R2/R8 no strobe last_idx", 64'(last_idx), 64'd6);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule